// File: doc/BRIEF.md
# ASCII Register Command Parser

This block sits behind a serial receiver used for engineering access. It takes one received byte at a time and builds a text command from it. When a complete, well-formed line arrives, it issues one request pulse: a register read, a register write, a channel resynchronise, or a start-exposure trigger. The request carries the module number, register address, data word or vector taken from the line. A malformed line produces an error pulse and no request.

A line begins with `+`. A command letter follows, and the letter may be upper or lower case. Then come hexadecimal fields, separated by runs of spaces or tabs. A line feed ends the line. A backspace throws away the whole line being built, and the parser then waits for the next `+`.

When the register bus returns the data of a read, a small formatter sends that word back over a byte handshake toward the serial transmitter. It sends the word as uppercase hex text followed by a line feed. The bit-level receiver, the transmitter and the bus are outside this block.

Top module: `cmd_line_parser`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all request pulses, `err_pulse` and `tx_valid` are low.
- R2: Bytes received while waiting for `+` (0x2B) are ignored, including line feeds, and produce no pulse.
- R3: A line `+R <module> <addr>` ending in line feed (0x0A) raises `rd_req` for one cycle, in the cycle after the line feed is accepted. `req_module` and `req_addr` carry the field values. Letters and hex digits are accepted in either case.
- R4: A line `+W <module> <addr> <data>` raises `wr_req` in the same way, with `req_module`, `req_addr` and `req_data`. Fields are separated by one or more space (0x20) or tab (0x09) bytes.
- R5: A line `+A <vector>` raises `sync_req`, with the 16-bit vector on `req_vector`.
- R6: A line `+S <vector>` raises `trig_req`, with the 8-bit vector on `req_vector`. The upper bits of `req_vector` are zero.
- R7: A backspace (0x08) abandons the line in progress without any pulse. The parser then waits for a new `+`, so a following complete line is served normally.
- R8: Each of the following gives `err_pulse` for one cycle after the line feed and no request: an unknown command letter, a byte that is not hex and not a separator, a field count that does not match the command, a digit directly after the letter, or an empty line `+` followed by line feed.
- R9: Each field has a digit limit: module 2, address 4, data 8, `A` vector 4, `S` vector 2. Leading zeros count toward the limit. A field with more digits than its limit is an error (as in R8). The value is never truncated.
- R10: A module number of zero in an `R` or `W` line is an error (as in R8).
- R11: After `rd_done`, the word on `rd_data` is sent as eight uppercase hex characters, most significant nibble first, then a line feed. Each character is held on `tx_data` with `tx_valid` until `tx_ready` is seen. An `rd_done` that arrives while a reply is being sent is ignored.
- R12: At most one of `rd_req`, `wr_req`, `sync_req`, `trig_req`, `err_pulse` is high in any cycle, each for exactly one cycle per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| rd_req | output | 1 | Register read request pulse |
| wr_req | output | 1 | Register write request pulse |
| sync_req | output | 1 | Resynchronise request pulse |
| trig_req | output | 1 | Start-exposure trigger pulse |
| err_pulse | output | 1 | Malformed line pulse |
| req_module | output | MOD_W | Module number of the last read or write |
| req_addr | output | ADDR_W | Register address of the last read or write |
| req_data | output | DATA_W | Data word of the last write |
| req_vector | output | VEC_W | Vector of the last resynchronise or trigger |
| rd_done | input | 1 | Read data returned by the bus |
| rd_data | input | DATA_W | Returned read data |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| tx_data | output | 8 | Reply byte |

## Verification
A wrong internal state shows up at the latest at the next line feed. It appears as a request of the wrong kind, a missing pulse, an error pulse on a valid line, or field values shifted into the wrong output. All of these are visible one cycle after the line feed byte. A fault in the field-index or digit counters shows as an error on the limit cases (two-digit versus three-digit module) or as a value mismatch on that same cycle. A fault in the reply formatter shows within the nine handshakes of a reply, as a wrong character, a wrong character count, or a character that changes while the transmitter is stalled.

// File: rtl/cmdp_pkg.sv
// Shared types and helpers for the ASCII register command parser.
// Assumes 8-bit ASCII bytes; holds no state.
package cmdp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_SYNC  = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_TRIG  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_LETTER = 2'd1,
        ST_POST   = 2'd2,
        ST_BODY   = 2'd3
    } pst_e;

    localparam logic [7:0] CH_PLUS = 8'h2B;
    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_BS   = 8'h08;
    localparam logic [7:0] CH_SP   = 8'h20;
    localparam logic [7:0] CH_TAB  = 8'h09;

    // Uppercase ASCII character for one nibble.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/cmdp_lexer.sv
// Byte classifier: decodes one received byte into hex digit, separator,
// framing characters and command letter. Purely combinational; case of
// letters is ignored.
module cmdp_lexer
    import cmdp_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       is_hex,
    output logic [3:0] hex_val,
    output logic       is_sep,
    output logic       is_lf,
    output logic       is_plus,
    output logic       is_bs,
    output cmd_e       cmd
);

    logic [7:0] folded;

    // Fold lowercase letters onto uppercase for the letter compares.
    assign folded = byte_i & 8'hDF;

    // Hex digit detection and value.
    always_comb begin
        is_hex  = 1'b0;
        hex_val = 4'h0;
        if (byte_i >= 8'h30 && byte_i <= 8'h39) begin
            is_hex  = 1'b1;
            hex_val = byte_i[3:0];
        end else if (folded >= 8'h41 && folded <= 8'h46) begin
            is_hex  = 1'b1;
            hex_val = folded[3:0] + 4'd9;
        end
    end

    // Framing and separator bytes.
    assign is_sep  = (byte_i == CH_SP) || (byte_i == CH_TAB);
    assign is_lf   = (byte_i == CH_LF);
    assign is_plus = (byte_i == CH_PLUS);
    assign is_bs   = (byte_i == CH_BS);

    // Command letter decode.
    always_comb begin
        unique case (folded)
            8'h41:   cmd = CMD_SYNC;
            8'h52:   cmd = CMD_READ;
            8'h57:   cmd = CMD_WRITE;
            8'h53:   cmd = CMD_TRIG;
            default: cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/cmdp_field_acc.sv
// Hex field accumulator: shifts in one nibble per push and counts digits.
// Assumes the caller never pushes past the width (it enforces digit limits).
module cmdp_field_acc #(
    parameter int W     = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [3:0]       digit,
    output logic [W-1:0]     value,
    output logic [CNT_W-1:0] count
);

    // Clear takes priority over a push in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
            count <= '0;
        end else if (push) begin
            value <= {value[W-5:0], digit};
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cmdp_hex_tx.sv
// Read reply formatter: sends a word as uppercase hex text, MSB nibble first,
// then a line feed, over a valid/ready byte handshake. A load while busy is
// ignored. Assumes DATA_W is a multiple of 4.
module cmdp_hex_tx
    import cmdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);

    localparam int NIB   = DATA_W / 4;
    localparam int IDX_W = $clog2(NIB + 1);

    logic              busy;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              last;

    assign last     = (idx == IDX_W'(NIB));
    assign tx_valid = busy;
    assign tx_data  = last ? CH_LF : nib_to_ascii(shreg[DATA_W-1 -: 4]);

    // Load a word when idle, step one character per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '0;
            idx   <= '0;
        end else if (!busy) begin
            if (load) begin
                busy  <= 1'b1;
                shreg <= word;
                idx   <= '0;
            end
        end else if (tx_ready) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                shreg <= {shreg[DATA_W-5:0], 4'h0};
                idx   <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmd_line_parser.sv
// ASCII register command parser. Assembles '+<letter> <hex> ... LF' lines
// from a byte strobe, checks field count, digit limits and module number,
// and pulses one request (or an error) in the cycle after the line feed.
// Read data returned by the bus is formatted back as hex text.
// Assumes at most one received byte per cycle; field widths are multiples
// of 4 and no wider than DATA_W.
module cmd_line_parser
    import cmdp_pkg::*;
#(
    parameter int MOD_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int VEC_W  = 16,
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rd_req,
    output logic              wr_req,
    output logic              sync_req,
    output logic              trig_req,
    output logic              err_pulse,
    output logic [MOD_W-1:0]  req_module,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [VEC_W-1:0]  req_vector,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);

    localparam int NSLOT    = 3;
    localparam int MOD_DIG  = MOD_W / 4;
    localparam int ADDR_DIG = ADDR_W / 4;
    localparam int DATA_DIG = DATA_W / 4;
    localparam int VEC_DIG  = VEC_W / 4;
    localparam int TRIG_DIG = TRIG_W / 4;
    localparam int DCNT_W   = $clog2(DATA_DIG + 1);

    // Lexer outputs
    logic       lx_hex, lx_sep, lx_lf, lx_plus, lx_bs;
    logic [3:0] lx_val;
    cmd_e       lx_cmd;

    // Line state
    pst_e       state;
    cmd_e       cmd;
    logic       bad;
    logic [1:0] fcnt;
    logic       in_field;

    // Field storage
    logic [DATA_W-1:0] acc_val;
    logic [DCNT_W-1:0] acc_cnt;
    logic [DATA_W-1:0] slot [NSLOT];
    logic [DATA_W-1:0] fin  [NSLOT];
    logic [NSLOT-1:0]  fits;

    // Field limits for the current command
    logic [DCNT_W-1:0] lim [NSLOT];
    logic [1:0]        need;
    logic [DCNT_W-1:0] cur_lim;
    logic [2:0]        nfields;

    // Actions
    logic live, act_start, act_commit, act_push, act_finish, line_ok, mod_zero;

    cmdp_lexer u_lex (
        .byte_i  (rx_data),
        .is_hex  (lx_hex),
        .hex_val (lx_val),
        .is_sep  (lx_sep),
        .is_lf   (lx_lf),
        .is_plus (lx_plus),
        .is_bs   (lx_bs),
        .cmd     (lx_cmd)
    );

    cmdp_field_acc #(.W(DATA_W), .CNT_W(DCNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (act_start || act_commit),
        .push  (act_push),
        .digit (lx_val),
        .value (acc_val),
        .count (acc_cnt)
    );

    cmdp_hex_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_done),
        .word     (rd_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data)
    );

    // Field count and per-field digit limits for each command.
    always_comb begin
        need = 2'd0;
        for (int i = 0; i < NSLOT; i++) lim[i] = '0;
        unique case (cmd)
            CMD_SYNC: begin
                need   = 2'd1;
                lim[0] = DCNT_W'(VEC_DIG);
            end
            CMD_READ: begin
                need   = 2'd2;
                lim[0] = DCNT_W'(MOD_DIG);
                lim[1] = DCNT_W'(ADDR_DIG);
            end
            CMD_WRITE: begin
                need   = 2'd3;
                lim[0] = DCNT_W'(MOD_DIG);
                lim[1] = DCNT_W'(ADDR_DIG);
                lim[2] = DCNT_W'(DATA_DIG);
            end
            CMD_TRIG: begin
                need   = 2'd1;
                lim[0] = DCNT_W'(TRIG_DIG);
            end
            default: need = 2'd0;
        endcase
    end

    // Digit limit of the field now being typed (zero past the last field).
    always_comb begin
        cur_lim = '0;
        for (int i = 0; i < NSLOT; i++)
            if (fcnt == 2'(i) && 2'(i) < need) cur_lim = lim[i];
    end

    // Final field values, overflow check and slot storage per field.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign fin[g]  = (in_field && fcnt == 2'(g)) ? acc_val : slot[g];
        assign fits[g] = ((fin[g] >> (4 * lim[g])) == '0);

        // Capture a finished field into its slot; cleared at each '+'.
        always_ff @(posedge clk) begin
            if (!rst_n || act_start)
                slot[g] <= '0;
            else if (act_commit && fcnt == 2'(g))
                slot[g] <= acc_val;
        end
    end

    // Decode the action of the byte now on the input.
    always_comb begin
        live       = rx_valid && !lx_bs;
        act_start  = live && state == ST_WAIT && lx_plus;
        act_commit = live && state == ST_BODY && lx_sep && in_field;
        act_push   = live && state == ST_BODY && lx_hex && (acc_cnt < cur_lim);
        act_finish = live && state != ST_WAIT && lx_lf;
        nfields    = {1'b0, fcnt} + 3'(in_field);
        mod_zero   = (cmd == CMD_READ || cmd == CMD_WRITE) && (fin[0] == '0);
        line_ok    = act_finish && state != ST_LETTER && !bad &&
                     nfields == {1'b0, need} && (&fits) && !mod_zero;
    end

    // Line state machine: framing, command letter, separators and digits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            cmd      <= CMD_NONE;
            bad      <= 1'b0;
            fcnt     <= '0;
            in_field <= 1'b0;
        end else if (rx_valid) begin
            if (lx_bs) begin
                state <= ST_WAIT;
            end else begin
                unique case (state)
                    ST_WAIT: begin
                        if (lx_plus) begin
                            state    <= ST_LETTER;
                            bad      <= 1'b0;
                            fcnt     <= '0;
                            in_field <= 1'b0;
                        end
                    end
                    ST_LETTER: begin
                        if (lx_lf) begin
                            state <= ST_WAIT;
                        end else begin
                            cmd   <= lx_cmd;
                            bad   <= (lx_cmd == CMD_NONE);
                            state <= ST_POST;
                        end
                    end
                    ST_POST: begin
                        if (lx_lf)       state <= ST_WAIT;
                        else if (lx_sep) state <= ST_BODY;
                        else             bad   <= 1'b1;
                    end
                    ST_BODY: begin
                        if (lx_lf) begin
                            state <= ST_WAIT;
                        end else if (lx_sep) begin
                            if (in_field) begin
                                fcnt     <= fcnt + 1'b1;
                                in_field <= 1'b0;
                            end
                        end else if (lx_hex) begin
                            if (acc_cnt < cur_lim) in_field <= 1'b1;
                            else                   bad      <= 1'b1;
                        end else begin
                            bad <= 1'b1;
                        end
                    end
                    default: state <= ST_WAIT;
                endcase
            end
        end
    end

    // Request pulses and their fields, registered at the line feed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req     <= 1'b0;
            wr_req     <= 1'b0;
            sync_req   <= 1'b0;
            trig_req   <= 1'b0;
            err_pulse  <= 1'b0;
            req_module <= '0;
            req_addr   <= '0;
            req_data   <= '0;
            req_vector <= '0;
        end else begin
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            sync_req  <= 1'b0;
            trig_req  <= 1'b0;
            err_pulse <= act_finish && !line_ok;
            if (line_ok) begin
                unique case (cmd)
                    CMD_READ: begin
                        rd_req     <= 1'b1;
                        req_module <= fin[0][MOD_W-1:0];
                        req_addr   <= fin[1][ADDR_W-1:0];
                    end
                    CMD_WRITE: begin
                        wr_req     <= 1'b1;
                        req_module <= fin[0][MOD_W-1:0];
                        req_addr   <= fin[1][ADDR_W-1:0];
                        req_data   <= fin[2];
                    end
                    CMD_SYNC: begin
                        sync_req   <= 1'b1;
                        req_vector <= fin[0][VEC_W-1:0];
                    end
                    CMD_TRIG: begin
                        trig_req   <= 1'b1;
                        req_vector <= fin[0][VEC_W-1:0];
                    end
                    default: err_pulse <= 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmdp_chk.sv
// Assertion checker for cmd_line_parser, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module cmdp_chk #(
    parameter int MOD_W  = 8,
    parameter int VEC_W  = 16,
    parameter int TRIG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [7:0]       rx_data,
    input logic             rd_req,
    input logic             wr_req,
    input logic             sync_req,
    input logic             trig_req,
    input logic             err_pulse,
    input logic [MOD_W-1:0] req_module,
    input logic [VEC_W-1:0] req_vector,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data
);

    logic any_pulse;
    assign any_pulse = rd_req || wr_req || sync_req || trig_req || err_pulse;

    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, sync_req, trig_req, err_pulse}));

    // R12
    pulse_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> $past(rx_valid && rx_data == 8'h0A));

    // R12
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |=> !any_pulse);

    // R10
    mod_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> (req_module != '0));

    // R6
    trig_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_req |-> ((req_vector >> TRIG_W) == '0));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind cmd_line_parser cmdp_chk #(.MOD_W(MOD_W), .VEC_W(VEC_W), .TRIG_W(TRIG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .sync_req   (sync_req),
    .trig_req   (trig_req),
    .err_pulse  (err_pulse),
    .req_module (req_module),
    .req_vector (req_vector),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data)
);

// File: tb/tb_cmd_line_parser.sv
`timescale 1ns/1ps
module tb_cmd_line_parser;

    localparam int TW = 8 * 24;
    typedef logic [TW-1:0] txt_t;

    localparam logic [2:0] K_NONE = 3'd0, K_RD = 3'd1, K_WR = 3'd2,
                           K_SY = 3'd3, K_TR = 3'd4, K_ER = 3'd5;

    typedef struct packed {
        txt_t        txt;
        logic [2:0]  kind;
        logic [3:0]  rq;
        logic [7:0]  md;
        logic [15:0] ad;
        logic [31:0] dt;
        logic [15:0] vc;
    } tv_t;

    localparam int NV = 22;
    localparam tv_t TV [NV] = '{
        '{txt_t'("+R 01 1234\n"),          K_RD, 4'd3,  8'h01, 16'h1234, 32'h0, 16'h0},     // R3
        '{txt_t'("+r a5 bEeF\n"),          K_RD, 4'd3,  8'hA5, 16'hBEEF, 32'h0, 16'h0},     // R3 case
        '{txt_t'("+W 02 0010 DEADBEEF\n"), K_WR, 4'd4,  8'h02, 16'h0010, 32'hDEADBEEF, 16'h0}, // R4
        '{txt_t'("+w\t3\t  7 cafe01\n"),   K_WR, 4'd4,  8'h03, 16'h0007, 32'h00CAFE01, 16'h0}, // R4 tabs
        '{txt_t'("+A ffff\n"),             K_SY, 4'd5,  8'h0,  16'h0, 32'h0, 16'hFFFF},     // R5
        '{txt_t'("+a 0\n"),                K_SY, 4'd5,  8'h0,  16'h0, 32'h0, 16'h0000},     // R5
        '{txt_t'("+S 7e\n"),               K_TR, 4'd6,  8'h0,  16'h0, 32'h0, 16'h007E},     // R6
        '{txt_t'("+Q 1\n"),                K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 letter
        '{txt_t'("+R 01 12g4\n"),          K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 non-hex
        '{txt_t'("+R 01\n"),               K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 missing
        '{txt_t'("+S 1 2\n"),              K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 extra
        '{txt_t'("+R01 1\n"),              K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 no sep
        '{txt_t'("+\n"),                   K_ER, 4'd8,  8'h0,  16'h0, 32'h0, 16'h0},        // R8 empty
        '{txt_t'("+R 001 1\n"),            K_ER, 4'd9,  8'h0,  16'h0, 32'h0, 16'h0},        // R9 module
        '{txt_t'("+W 1 1 123456789\n"),    K_ER, 4'd9,  8'h0,  16'h0, 32'h0, 16'h0},        // R9 data
        '{txt_t'("+S 100\n"),              K_ER, 4'd9,  8'h0,  16'h0, 32'h0, 16'h0},        // R9 trig
        '{txt_t'("+A 12345\n"),            K_ER, 4'd9,  8'h0,  16'h0, 32'h0, 16'h0},        // R9 vector
        '{txt_t'("+R 00 10\n"),            K_ER, 4'd10, 8'h0,  16'h0, 32'h0, 16'h0},        // R10
        '{txt_t'("+W 0 1 2\n"),            K_ER, 4'd10, 8'h0,  16'h0, 32'h0, 16'h0},        // R10
        '{txt_t'("xyz\n\n"),               K_NONE, 4'd2, 8'h0, 16'h0, 32'h0, 16'h0},        // R2
        '{txt_t'("+R 1 2\010\n"),          K_NONE, 4'd7, 8'h0, 16'h0, 32'h0, 16'h0},        // R7
        '{txt_t'("+R 1 2\010+S 5\n"),      K_TR, 4'd7,  8'h0,  16'h0, 32'h0, 16'h0005}      // R7 recover
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rd_req, wr_req, sync_req, trig_req, err_pulse;
    logic [7:0]  req_module;
    logic [15:0] req_addr;
    logic [31:0] req_data;
    logic [15:0] req_vector;
    logic        rd_done = 1'b0;
    logic [31:0] rd_data = 32'h0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pulse  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cmd_line_parser dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_req(rd_req), .wr_req(wr_req), .sync_req(sync_req), .trig_req(trig_req),
        .err_pulse(err_pulse), .req_module(req_module), .req_addr(req_addr),
        .req_data(req_data), .req_vector(req_vector), .rd_done(rd_done),
        .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    // Count pulse cycles of all request and error outputs.
    always @(negedge clk)
        n_pulse <= n_pulse + int'(rd_req) + int'(wr_req) + int'(sync_req)
                           + int'(trig_req) + int'(err_pulse);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [2:0] seen_kind();
        if (rd_req)    return K_RD;
        if (wr_req)    return K_WR;
        if (sync_req)  return K_SY;
        if (trig_req)  return K_TR;
        if (err_pulse) return K_ER;
        return K_NONE;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] k;
        int         base;
        string      tag;
        logic [7:0] exp_txt [9];

        // R1 reset state
        repeat (4) @(negedge clk);
        check({rd_req, wr_req, sync_req, trig_req, err_pulse, tx_valid} == 6'b0,
              "R1", {26'h0, rd_req, wr_req, sync_req, trig_req, err_pulse, tx_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rd_req, wr_req, sync_req, trig_req, err_pulse, tx_valid} == 6'b0,
              "R1", {26'h0, rd_req, wr_req, sync_req, trig_req, err_pulse, tx_valid}, 32'h0);

        // Table walk: each line, then pulse kind, pulse count and fields.
        for (int v = 0; v < NV; v++) begin
            tag  = $sformatf("R%0d line %0d", TV[v].rq, v);
            base = n_pulse;
            for (int c = 23; c >= 0; c--)
                if (TV[v].txt[8*c +: 8] != 8'h00) send_byte(TV[v].txt[8*c +: 8]);
            k = seen_kind();
            check(k == TV[v].kind, tag, {29'h0, k}, {29'h0, TV[v].kind});
            repeat (2) @(negedge clk);
            #1;
            check(n_pulse - base == (TV[v].kind == K_NONE ? 0 : 1), {tag, " R12 count"},
                  n_pulse - base, (TV[v].kind == K_NONE ? 0 : 1));
            if (TV[v].kind == K_RD || TV[v].kind == K_WR) begin
                check(req_module == TV[v].md, {tag, " module"}, {24'h0, req_module}, {24'h0, TV[v].md});
                check(req_addr == TV[v].ad, {tag, " addr"}, {16'h0, req_addr}, {16'h0, TV[v].ad});
            end
            if (TV[v].kind == K_WR)
                check(req_data == TV[v].dt, {tag, " data"}, req_data, TV[v].dt);
            if (TV[v].kind == K_SY || TV[v].kind == K_TR)
                check(req_vector == TV[v].vc, {tag, " vector"}, {16'h0, req_vector}, {16'h0, TV[v].vc});
        end

        // R11 read reply with a stalled transmitter and an ignored second load.
        exp_txt = '{8'h30, 8'h41, 8'h31, 8'h42, 8'h32, 8'h43, 8'h33, 8'h44, 8'h0A};
        @(negedge clk);
        rd_done = 1'b1;
        rd_data = 32'h0A1B2C3D;
        @(negedge clk);
        rd_done = 1'b0;
        check(tx_valid && tx_data == 8'h30, "R11 first char", {23'h0, tx_valid, tx_data}, 32'h130);
        rd_done = 1'b1;
        rd_data = 32'hFFFFFFFF;
        @(negedge clk);
        rd_done = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_valid && tx_data == 8'h30, "R11 held", {23'h0, tx_valid, tx_data}, 32'h130);
        tx_ready = 1'b1;
        for (int c = 0; c < 9; c++) begin
            check(tx_valid && tx_data == exp_txt[c], $sformatf("R11 char %0d", c),
                  {23'h0, tx_valid, tx_data}, {23'h1, exp_txt[c]});
            @(negedge clk);
        end
        check(!tx_valid, "R11 end", {31'h0, tx_valid}, 32'h0);

        // R11 letters come out uppercase.
        exp_txt = '{8'h46, 8'h45, 8'h44, 8'h43, 8'h42, 8'h41, 8'h39, 8'h38, 8'h0A};
        rd_done = 1'b1;
        rd_data = 32'hFEDCBA98;
        @(negedge clk);
        rd_done = 1'b0;
        for (int c = 0; c < 9; c++) begin
            check(tx_valid && tx_data == exp_txt[c], $sformatf("R11 upper %0d", c),
                  {23'h0, tx_valid, tx_data}, {23'h1, exp_txt[c]});
            @(negedge clk);
        end
        check(!tx_valid, "R11 end2", {31'h0, tx_valid}, 32'h0);
        tx_ready = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule